// File: doc/BRIEF.md
# Virtual Address Translator with Access Check

This block turns a 32-bit virtual address into a 29-bit physical address in one registered step. Fixed rules for the address space come first. Addresses that fall in the direct-mapped windows are passed through with their three top bits cleared. While translation is switched off, every address is passed through the same way. All other addresses are compared at once against a small, fully associative set of page entries. Each entry covers a page of one of four sizes and may be private to an address-space identifier (ASID) or shared by all of them.

When exactly one entry matches, the block builds the physical address from that entry's page number and the in-page offset. It then checks the access against the entry's protection and dirty bits. Misses, multiple matches, first writes to clean pages and protection faults each produce their own exception code. Code 0 means no exception. The surrounding core fills and replaces entries elsewhere. It presents the entry array and the access on the same cycle as a request strobe. The result and a response strobe come back one clock later.

Top module: `tlb_xlate`

## Requirements
- R1: Every cycle with `reqValid` high is followed one clock later by `rspValid` high, carrying that request's result. `rspValid` is low in the cycle after any cycle without a request.
- R2: Addresses from 0x80000000 to 0xBFFFFFFF, and addresses at or above 0xE0000000, skip the lookup when accessed in privileged mode. For them `paddr` is the address bits [28:0], `hit` is 0 and `excCode` is 0.
- R3: A user-mode access to those windows gets the same pass-through result only when the address lies from 0xE0000000 to 0xE4000000 inclusive. Any other user-mode access there returns `excCode` 0x040 for a read or fetch and 0x060 for a write, with `hit` 0 and `paddr` 0.
- R4: With `xlateEn` low, every address outside those windows returns `paddr` equal to address bits [28:0], with `hit` 0 and `excCode` 0.
- R5: An entry's size code selects the page: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. The entry matches when the address and {VPN, 10 zero bits} agree above the in-page bits. On a single match, `hit` is 1 and `paddr` is {PPN, 10 zero bits} with the in-page bits replaced by the address's in-page bits.
- R6: The ASID takes part in matching only when `singleVirt` and `privMode` are both 0. An entry whose ASID differs from `curAsid` still matches if its shared bit is set.
- R7: Two or more matching valid entries give `excCode` 0x140, with `hit` 0 and `paddr` 0.
- R8: No matching entry gives `excCode` 0x040 for a read or fetch and 0x060 for a write, with `hit` 0 and `paddr` 0.
- R9: For data accesses, protection bit 1 marks a page as privileged-only and protection bit 0 marks it writable. A user-mode access to a privileged-only page returns 0x0A0 on a read and 0x0C0 on a write. A write to a page that is not writable returns 0x0C0. A write takes priority over the fetch flag, so an access with both `isFetch` and `isWrite` set is handled as a data write.
- R10: A fetch (`isFetch` 1, `isWrite` 0) in privileged mode from an entry whose protection bit 1 is clear returns 0x0A0. A user-mode fetch is not checked against protection.
- R11: A permitted write to a single matching entry whose dirty bit is 0 returns 0x080, with `hit` 1.
- R12: While `rstN` is low, `rspValid`, `hit`, `excCode` and `paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| vaddr | input | 32 | Virtual address |
| isWrite | input | 1 | Access is a write |
| isFetch | input | 1 | Access is an instruction fetch |
| privMode | input | 1 | Core is in privileged mode |
| xlateEn | input | 1 | Address translation enabled |
| singleVirt | input | 1 | Single virtual space: ignore ASIDs |
| curAsid | input | 8 | Current address-space identifier |
| entValid | input | NUM_ENT | Per-entry valid bit |
| entAsid | input | NUM_ENT*8 | Per-entry ASID, entry i at [8i +: 8] |
| entShared | input | NUM_ENT | Per-entry shared bit |
| entSize | input | NUM_ENT*2 | Per-entry size code, entry i at [2i +: 2] |
| entVpn | input | NUM_ENT*22 | Per-entry virtual page number (address bits 31:10) |
| entPpn | input | NUM_ENT*19 | Per-entry physical page number (address bits 28:10) |
| entProt | input | NUM_ENT*2 | Per-entry protection, bit 1 privileged-only, bit 0 writable |
| entDirty | input | NUM_ENT | Per-entry dirty bit |
| rspValid | output | 1 | Result strobe, one clock after the request |
| paddr | output | 29 | Physical address |
| hit | output | 1 | Exactly one entry matched |
| excCode | output | 12 | Exception code, 0 when none |

## Verification
The assertions take three things for granted. The access and the whole entry array hold known, non-X values at every clock edge where `reqValid` is high. Entries are not expected to be unique, since overlap is a reported condition rather than a forbidden one. A request may come on every cycle. The stimulus changes all inputs only on the falling clock edge and holds them steady across the sampling edge. Besides directed cases for every page size, window boundary and fault, it replaces the entry array with random contents that are deliberately clustered, so that overlaps and ASID conflicts do occur.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  typedef struct packed {
    logic load;
    logic bypass;
    logic userDeny;
    logic useAsid;
  } xlateCtl_t;

  localparam logic [11:0] EXC_NONE    = 12'h000;
  localparam logic [11:0] EXC_RD_MISS = 12'h040;
  localparam logic [11:0] EXC_WR_MISS = 12'h060;
  localparam logic [11:0] EXC_CLEAN   = 12'h080;
  localparam logic [11:0] EXC_PROT_RD = 12'h0A0;
  localparam logic [11:0] EXC_PROT_WR = 12'h0C0;
  localparam logic [11:0] EXC_MULTI   = 12'h140;

  function automatic logic [31:0] pageMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    pageMask = 32'h0000_03FF;
      2'd1:    pageMask = 32'h0000_0FFF;
      2'd2:    pageMask = 32'h0000_FFFF;
      default: pageMask = 32'h000F_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/tlbx_ctrl.sv
module tlbx_ctrl
  import tlbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] vaddr,
  input  logic        privMode,
  input  logic        xlateEn,
  input  logic        singleVirt,
  output xlateCtl_t   ctl,
  output logic        rspValid
);

  logic inFixed;
  logic inUserWin;

  assign inFixed   = (vaddr[31:30] == 2'b10) || (vaddr[31:29] == 3'b111);
  assign inUserWin = (vaddr >= 32'hE000_0000) && (vaddr <= 32'hE400_0000);

  always_comb begin
    ctl.load     = reqValid;
    ctl.bypass   = inFixed || !xlateEn;
    ctl.userDeny = inFixed && !privMode && !inUserWin;
    ctl.useAsid  = !singleVirt && !privMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R1

endmodule

// File: rtl/tlbx_datapath.sv
module tlbx_datapath
  import tlbx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int ASID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xlateCtl_t               ctl,
  input  logic [31:0]             vaddr,
  input  logic                    isWrite,
  input  logic                    isFetch,
  input  logic                    privMode,
  input  logic [ASID_W-1:0]       curAsid,
  input  logic [NUM_ENT-1:0]      entValid,
  input  logic [NUM_ENT*ASID_W-1:0] entAsid,
  input  logic [NUM_ENT-1:0]      entShared,
  input  logic [NUM_ENT*2-1:0]    entSize,
  input  logic [NUM_ENT*22-1:0]   entVpn,
  input  logic [NUM_ENT*19-1:0]   entPpn,
  input  logic [NUM_ENT*2-1:0]    entProt,
  input  logic [NUM_ENT-1:0]      entDirty,
  output logic [28:0]             paddr,
  output logic                    hit,
  output logic [11:0]             excCode
);

  localparam int VPN_W = 22;
  localparam int PPN_W = 19;
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CNT_W = $clog2(NUM_ENT + 1);

  logic [NUM_ENT-1:0] matchVec;
  logic [31:0]        entMask [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [31:0] base;
    logic        asidOk;
    assign entMask[i] = pageMask(entSize[2*i +: 2]);
    assign base       = {entVpn[VPN_W*i +: VPN_W], 10'b0};
    assign asidOk     = !ctl.useAsid || entShared[i] ||
                        (entAsid[ASID_W*i +: ASID_W] == curAsid);
    assign matchVec[i] = entValid[i] && asidOk &&
                         ((vaddr & ~entMask[i]) == (base & ~entMask[i]));
  end

  logic [CNT_W-1:0] matchCnt;
  logic [IDX_W-1:0] selIdx;

  always_comb begin
    matchCnt = '0;
    selIdx   = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (matchVec[i]) begin
        matchCnt = matchCnt + CNT_W'(1);
        selIdx   = IDX_W'(i);
      end
    end
  end

  logic [31:0]      selMask;
  logic [PPN_W-1:0] selPpn;
  logic [1:0]       selProt;
  logic             selDirty;

  assign selMask  = entMask[selIdx];
  assign selPpn   = entPpn[selIdx*PPN_W +: PPN_W];
  assign selProt  = entProt[selIdx*2 +: 2];
  assign selDirty = entDirty[selIdx];

  logic [28:0] nPaddr;
  logic        nHit;
  logic [11:0] nExc;

  always_comb begin
    nPaddr = '0;
    nHit   = 1'b0;
    nExc   = EXC_NONE;
    if (ctl.bypass) begin
      if (ctl.userDeny) nExc = isWrite ? EXC_WR_MISS : EXC_RD_MISS;
      else              nPaddr = vaddr[28:0];
    end else if (matchCnt == '0) begin
      nExc = isWrite ? EXC_WR_MISS : EXC_RD_MISS;
    end else if (matchCnt > CNT_W'(1)) begin
      nExc = EXC_MULTI;
    end else begin
      nHit   = 1'b1;
      nPaddr = ({selPpn, 10'b0} & ~selMask[28:0]) | (vaddr[28:0] & selMask[28:0]);
      if (isFetch && !isWrite) begin
        if (privMode && !selProt[1]) nExc = EXC_PROT_RD;
      end else if (!privMode && selProt[1]) begin
        nExc = isWrite ? EXC_PROT_WR : EXC_PROT_RD;
      end else if (isWrite && !selProt[0]) begin
        nExc = EXC_PROT_WR;
      end else if (isWrite && !selDirty) begin
        nExc = EXC_CLEAN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr   <= '0;
      hit     <= 1'b0;
      excCode <= EXC_NONE;
    end else if (ctl.load) begin
      paddr   <= nPaddr;
      hit     <= nHit;
      excCode <= nExc;
    end
  end

  AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && ctl.bypass && !ctl.userDeny |=>
      (paddr == $past(vaddr[28:0])) && !hit && (excCode == EXC_NONE)); // R2
  AST_USER_DENY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && ctl.userDeny |=>
      !hit && ((excCode == EXC_RD_MISS) || (excCode == EXC_WR_MISS))); // R3
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && !ctl.bypass && (matchVec == '0) |=>
      !hit && (excCode == ($past(isWrite) ? EXC_WR_MISS : EXC_RD_MISS))); // R8
  AST_MULTI_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load && !ctl.bypass && !$onehot0(matchVec) |=>
      !hit && (excCode == EXC_MULTI)); // R7

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlbx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int ASID_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [31:0]               vaddr,
  input  logic                      isWrite,
  input  logic                      isFetch,
  input  logic                      privMode,
  input  logic                      xlateEn,
  input  logic                      singleVirt,
  input  logic [ASID_W-1:0]         curAsid,
  input  logic [NUM_ENT-1:0]        entValid,
  input  logic [NUM_ENT*ASID_W-1:0] entAsid,
  input  logic [NUM_ENT-1:0]        entShared,
  input  logic [NUM_ENT*2-1:0]      entSize,
  input  logic [NUM_ENT*22-1:0]     entVpn,
  input  logic [NUM_ENT*19-1:0]     entPpn,
  input  logic [NUM_ENT*2-1:0]      entProt,
  input  logic [NUM_ENT-1:0]        entDirty,
  output logic                      rspValid,
  output logic [28:0]               paddr,
  output logic                      hit,
  output logic [11:0]               excCode
);

  xlateCtl_t ctl;

  tlbx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .privMode(privMode), .xlateEn(xlateEn), .singleVirt(singleVirt),
    .ctl(ctl), .rspValid(rspValid)
  );

  tlbx_datapath #(.NUM_ENT(NUM_ENT), .ASID_W(ASID_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vaddr(vaddr), .isWrite(isWrite),
    .isFetch(isFetch), .privMode(privMode), .curAsid(curAsid),
    .entValid(entValid), .entAsid(entAsid), .entShared(entShared),
    .entSize(entSize), .entVpn(entVpn), .entPpn(entPpn),
    .entProt(entProt), .entDirty(entDirty),
    .paddr(paddr), .hit(hit), .excCode(excCode)
  );

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic isWrite = 1'b0, isFetch = 1'b0, privMode = 1'b0;
  logic xlateEn = 1'b1, singleVirt = 1'b0;
  logic [7:0] curAsid = '0;
  logic [N-1:0] entValid = '0, entShared = '0, entDirty = '0;
  logic [N*8-1:0] entAsid = '0;
  logic [N*2-1:0] entSize = '0, entProt = '0;
  logic [N*22-1:0] entVpn = '0;
  logic [N*19-1:0] entPpn = '0;
  logic rspValid, hit;
  logic [28:0] paddr;
  logic [11:0] excCode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [28:0] expPa;
  logic        expHit;
  logic [11:0] expExc;
  string       expTag;

  always #4 clk = ~clk;

  tlb_xlate #(.NUM_ENT(N), .ASID_W(8)) i_tlb_xlate (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic setEnt(input int i, input bit v, input logic [7:0] asid,
                        input bit sh, input logic [1:0] sz, input logic [21:0] vpn,
                        input logic [18:0] ppn, input logic [1:0] prot, input bit d);
    entValid[i] = v; entShared[i] = sh; entDirty[i] = d;
    entAsid[i*8 +: 8] = asid; entSize[i*2 +: 2] = sz; entProt[i*2 +: 2] = prot;
    entVpn[i*22 +: 22] = vpn; entPpn[i*19 +: 19] = ppn;
  endtask

  // Behavioural reference built from the requirements
  function automatic void model(input logic [31:0] a, input bit w, input bit f, input bit pr);
    bit fix, useAsid, fetch;
    int cnt, sel, bits;
    logic [31:0] msk, base, pp;
    logic [1:0] prot;
    fix = (a >= 32'h8000_0000 && a <= 32'hBFFF_FFFF) || a >= 32'hE000_0000;
    expPa = '0; expHit = 1'b0; expExc = 12'h000;
    if (fix || !xlateEn) begin
      if (fix && !pr && !(a >= 32'hE000_0000 && a <= 32'hE400_0000)) begin
        expExc = w ? 12'h060 : 12'h040; expTag = "R3";
      end else begin
        expPa = a[28:0];
        expTag = fix ? (pr ? "R2" : "R3") : "R4";
      end
      return;
    end
    useAsid = !singleVirt && !pr;
    cnt = 0; sel = 0;
    for (int i = 0; i < N; i++) begin
      case (entSize[i*2 +: 2]) 2'd0: bits = 10; 2'd1: bits = 12; 2'd2: bits = 16; default: bits = 20; endcase
      msk = (32'h1 << bits) - 1;
      base = {entVpn[i*22 +: 22], 10'b0};
      if (entValid[i] && (!useAsid || entShared[i] || entAsid[i*8 +: 8] == curAsid) &&
          ((a & ~msk) == (base & ~msk))) begin
        cnt++; sel = i;
      end
    end
    if (cnt == 0) begin expExc = w ? 12'h060 : 12'h040; expTag = "R8"; return; end
    if (cnt > 1) begin expExc = 12'h140; expTag = "R7"; return; end
    case (entSize[sel*2 +: 2]) 2'd0: bits = 10; 2'd1: bits = 12; 2'd2: bits = 16; default: bits = 20; endcase
    msk = (32'h1 << bits) - 1;
    pp = {3'b0, entPpn[sel*19 +: 19], 10'b0};
    expPa = 29'((pp & ~msk) | (a & msk));
    expHit = 1'b1;
    prot = entProt[sel*2 +: 2];
    fetch = f && !w;
    expTag = useAsid ? "R6" : "R5";
    if (fetch) begin
      expTag = "R10";
      if (pr && !prot[1]) expExc = 12'h0A0;
    end else if (!pr && prot[1]) begin
      expExc = w ? 12'h0C0 : 12'h0A0; expTag = "R9";
    end else if (w && !prot[0]) begin
      expExc = 12'h0C0; expTag = "R9";
    end else if (w && !entDirty[sel]) begin
      expExc = 12'h080; expTag = "R11";
    end
  endfunction

  task automatic req(input logic [31:0] a, input bit w, input bit f, input bit pr);
    vaddr = a; isWrite = w; isFetch = f; privMode = pr; reqValid = 1'b1;
    model(a, w, f, pr);
    @(negedge clk);
    chk(rspValid === 1'b1, "R1", "rspValid", 32'(rspValid), 32'd1);
    chk(paddr === expPa, expTag, "paddr", 32'(paddr), 32'(expPa));
    chk(hit === expHit, expTag, "hit", 32'(hit), 32'(expHit));
    chk(excCode === expExc, expTag, "excCode", 32'(excCode), 32'(expExc));
    reqValid = 1'b0;
  endtask

  task automatic idle();
    reqValid = 1'b0;
    vaddr = $urandom;
    @(negedge clk);
    chk(rspValid === 1'b0, "R1", "rspValid idle", 32'(rspValid), 32'd0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rspValid === 1'b0 && hit === 1'b0, "R12", "strobes in reset", {30'b0, rspValid, hit}, 32'd0);
    chk(excCode === 12'h0 && paddr === 29'h0, "R12", "result in reset", 32'(excCode) | 32'(paddr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    idle();

    setEnt(0, 1, 8'd5, 0, 2'd1, 22'h01000, 19'h05000, 2'b11, 1);
    setEnt(1, 1, 8'd7, 1, 2'd0, 22'h02000, 19'h00123, 2'b01, 0);
    setEnt(2, 1, 8'd5, 0, 2'd2, 22'h04000, 19'h10040, 2'b10, 1);
    setEnt(3, 1, 8'd9, 0, 2'd3, 22'h40000, 19'h00400, 2'b00, 1);
    curAsid = 8'd5;

    // R2 / R3 fixed windows
    req(32'h8123_4567, 0, 0, 1);
    req(32'hBFFF_FFFF, 1, 0, 1);
    req(32'hF000_0010, 0, 0, 1);
    req(32'h9000_0000, 0, 0, 0);
    req(32'h9000_0000, 1, 0, 0);
    req(32'hE000_0000, 1, 0, 0);
    req(32'hE400_0000, 0, 0, 0);
    req(32'hE400_0001, 0, 0, 0);
    req(32'hDFFF_FFFF, 0, 0, 1);
    idle();
    // R4 translation off
    xlateEn = 1'b0;
    req(32'h7234_5678, 1, 0, 0);
    xlateEn = 1'b1;
    // R5 sizes
    req(32'h0040_0ABC, 0, 0, 1);
    req(32'h0040_1000, 0, 0, 1);
    req(32'h0080_03FF, 0, 0, 1);
    req(32'h0080_0400, 0, 0, 1);
    req(32'h0100_F00D, 0, 0, 1);
    req(32'h100F_FFFF, 0, 0, 1);
    // R6 ASID
    curAsid = 8'd6;
    req(32'h0040_0010, 0, 0, 0);
    req(32'h0080_0010, 0, 0, 0);
    singleVirt = 1'b1;
    req(32'h0040_0010, 0, 0, 0);
    singleVirt = 1'b0;
    curAsid = 8'd5;
    // R9 protection, R10 fetch, R11 clean write
    req(32'h0100_0000, 0, 0, 0);
    req(32'h0100_0000, 1, 0, 1);
    req(32'h0100_0000, 1, 1, 1);
    curAsid = 8'd9;
    req(32'h1000_0000, 1, 0, 0);
    req(32'h1000_0000, 0, 1, 1);
    req(32'h1000_0000, 0, 1, 0);
    curAsid = 8'd7;
    req(32'h0080_0000, 1, 0, 0);
    req(32'h0080_0000, 1, 0, 1);
    // R7 multi-hit
    setEnt(3, 1, 8'd5, 0, 2'd3, 22'h01000, 19'h00400, 2'b00, 1);
    req(32'h0040_0004, 0, 0, 1);
    req(32'h0040_0004, 1, 1, 1);
    // R8 miss
    req(32'h3000_0000, 0, 1, 1);
    req(32'h3000_0000, 1, 0, 1);

    // random phase
    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0) begin
        for (int e = 0; e < N; e++)
          setEnt(e, $urandom_range(0, 3) != 0, 8'($urandom_range(0, 2)), $urandom_range(0, 3) == 0,
                 2'($urandom), {16'h0, 6'($urandom)} << 2, 19'($urandom), 2'($urandom), 1'($urandom));
        xlateEn = $urandom_range(0, 7) != 0;
        singleVirt = $urandom_range(0, 3) == 0;
        curAsid = 8'($urandom_range(0, 2));
      end
      if ($urandom_range(0, 5) == 0) idle();
      else begin
        logic [31:0] a;
        a = ($urandom_range(0, 4) == 0) ? 32'($urandom) : {16'h0, 4'($urandom), 12'($urandom)};
        req(a, 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end
    idle();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule